// File: doc/BRIEF.md
# Indirect-Access Byte Memory Port with Window Locks

This block puts a byte-addressed memory behind a narrow window of four byte-wide offsets. Software first builds a 16-bit pointer by writing its two halves through two of the offsets, then moves data through a third offset. A data write stores one byte at the pointer and returns the pointer to zero, so every store sequence starts by loading the address again. A data read returns the byte at the pointer on the cycle after the read strobe. Reads also leave the pointer where it is, so repeated reads of one location need no reload.

Two 16-byte address windows, 0x20–0x2F and 0x30–0x3F, can each be protected by a lock bit. A separate toggle command inverts one lock bit. While a window is locked, stores into it are dropped and reads from it return 0xFF. Pointers at or beyond the memory size behave the same way. The memory size is a parameter. Upper locations that might hold clock registers in a larger system are plain storage here.

Top module: `nvp_port`

## Requirements
- R1: A write at offset 0 replaces bits 7:0 of the pointer and leaves bits 15:8 unchanged.
- R2: A write at offset 1 replaces bits 15:8 of the pointer and leaves bits 7:0 unchanged.
- R3: A write at offset 3 stores the data byte at the pointer address, and the pointer reads as 0x0000 from the next cycle on.
- R4: A read at offset 3 makes `rdata` equal to the byte at the pointer address in the cycle after the read strobe.
- R5: A read at offset 0, 1 or 2 makes `rdata` equal to 0xFF in the cycle after the strobe.
- R6: A write at offset 2 changes neither the pointer nor the memory.
- R7: When lock bit 0 is set, stores to addresses 0x20–0x2F are dropped. When lock bit 1 is set, stores to 0x30–0x3F are dropped. Addresses outside a locked window are not affected.
- R8: A read at offset 3 whose pointer lies in a locked window returns 0xFF.
- R9: A pulse on `lock_tgl` inverts the lock bit chosen by `lock_sel` and leaves the other lock bit unchanged.
- R10: Reset clears the pointer and both lock bits and sets `rdata` to 0xFF.
- R11: A store with the pointer at or above MEM_BYTES is dropped and does not write the aliased lower location. A read there returns 0xFF.
- R12: `rdata` keeps its value in every cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected offset |
| rd_en | input | 1 | Read strobe for the selected offset |
| offset | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| wdata | input | 8 | Write byte |
| lock_tgl | input | 1 | Invert the lock bit selected by lock_sel |
| lock_sel | input | 1 | Lock bit index (0: 0x20–0x2F, 1: 0x30–0x3F) |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `lock_sel` names an existing lock bit whenever `lock_tgl` is high. The stimulus performs one access per cycle and leaves an idle cycle between accesses. Lock toggles are issued alone, and lock indices are drawn only from the valid range. Before the random phase, every memory location is written with a known byte, so every read has a defined expected value.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic [1:0] {
    OFS_PTR_LO = 2'd0,
    OFS_PTR_HI = 2'd1,
    OFS_SPARE  = 2'd2,
    OFS_DATA   = 2'd3
  } nvp_ofs_e;

  localparam logic [7:0] NVP_BLANK = 8'hFF;
endpackage

// File: rtl/nvp_ptr.sv
module nvp_ptr #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          clr,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (ld_lo) ptr[DW-1:0] <= din;
    else if (ld_hi) ptr[AW-1:DW] <= din;
  end
endmodule

// File: rtl/nvp_lock.sv
module nvp_lock #(
  parameter int AW        = 16,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int SW = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tgl,
  input  logic [SW-1:0]        sel,
  input  logic [AW-1:0]        ptr,
  output logic [NUM_LOCKS-1:0] locks,
  output logic                 hit
);
  logic [NUM_LOCKS-1:0] in_win;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
    localparam logic [AW:0] LO = (AW+1)'(LOCK_BASE + i * LOCK_SPAN);
    localparam logic [AW:0] HI = (AW+1)'(LOCK_BASE + (i + 1) * LOCK_SPAN);

    always_ff @(posedge clk) begin
      if (rst) locks[i] <= 1'b0;
      else if (tgl && sel == SW'(i)) locks[i] <= ~locks[i];
    end

    assign in_win[i] = ({1'b0, ptr} >= LO) && ({1'b0, ptr} < HI);
  end

  assign hit = |(in_win & locks);
endmodule

// File: rtl/nvp_mem.sv
module nvp_mem #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= din;
    if (re) dout <= store[addr];
  end
endmodule

// File: rtl/nvp_port.sv
module nvp_port
  import nvp_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int DW        = 8,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int AW = 2 * DW,
  localparam int IW = $clog2(MEM_BYTES),
  localparam int SW = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    offset,
  input  logic [DW-1:0] wdata,
  input  logic          lock_tgl,
  input  logic [SW-1:0] lock_sel,
  output logic [DW-1:0] rdata
);
  localparam logic [AW:0] LIMIT = (AW+1)'(MEM_BYTES);

  logic [AW-1:0]        ptr_q;
  logic [NUM_LOCKS-1:0] lock_q;
  logic                 lock_hit;
  logic                 in_range, allow;
  logic                 wr_data, rd_data, mem_we, mem_re;
  logic [DW-1:0]        ram_q;
  logic                 pass_q;
  nvp_ofs_e             ofs;

  assign ofs      = nvp_ofs_e'(offset);
  assign wr_data  = wr_en && (ofs == OFS_DATA);
  assign rd_data  = rd_en && (ofs == OFS_DATA);
  assign in_range = {1'b0, ptr_q} < LIMIT;
  assign allow    = in_range && !lock_hit;
  assign mem_we   = wr_data && allow;
  assign mem_re   = rd_data && allow;

  nvp_ptr #(.DW(DW)) ptr_i (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (wr_en && ofs == OFS_PTR_LO),
    .ld_hi (wr_en && ofs == OFS_PTR_HI),
    .clr   (wr_data),
    .din   (wdata),
    .ptr   (ptr_q)
  );

  nvp_lock #(
    .AW(AW), .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) lock_i (
    .clk   (clk),
    .rst   (rst),
    .tgl   (lock_tgl),
    .sel   (lock_sel),
    .ptr   (ptr_q),
    .locks (lock_q),
    .hit   (lock_hit)
  );

  nvp_mem #(.DEPTH(MEM_BYTES), .DW(DW)) mem_i (
    .clk  (clk),
    .we   (mem_we),
    .re   (mem_re),
    .addr (ptr_q[IW-1:0]),
    .din  (wdata),
    .dout (ram_q)
  );

  // Qualifier kept beside the RAM output register; RAM itself has no reset.
  always_ff @(posedge clk) begin
    if (rst) pass_q <= 1'b0;
    else if (rd_en) pass_q <= mem_re;
  end

  assign rdata = pass_q ? ram_q : NVP_BLANK;
endmodule

// File: rtl/nvp_port_chk.sv
module nvp_port_chk #(
  parameter int MEM_BYTES = 2048,
  parameter int DW        = 8,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int AW = 2 * DW,
  localparam int SW = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [1:0]           offset,
  input logic [DW-1:0]        wdata,
  input logic                 lock_tgl,
  input logic [SW-1:0]        lock_sel,
  input logic [DW-1:0]        rdata,
  input logic [AW-1:0]        ptr,
  input logic [NUM_LOCKS-1:0] locks,
  input logic                 mem_we
);
  logic guarded, oor;

  always_comb begin
    int p;
    p = int'(ptr);
    guarded = 1'b0;
    for (int i = 0; i < NUM_LOCKS; i++)
      if (p >= LOCK_BASE && (p - LOCK_BASE) / LOCK_SPAN == i && locks[i]) guarded = 1'b1;
    oor = p >= MEM_BYTES;
  end

  p_ptr_lo_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en && offset == 2'd0 |=> ptr[DW-1:0] == $past(wdata) && ptr[AW-1:DW] == $past(ptr[AW-1:DW]));

  p_ptr_hi_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && offset == 2'd1 |=> ptr[AW-1:DW] == $past(wdata) && ptr[DW-1:0] == $past(ptr[DW-1:0]));

  p_ptr_clr_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en && offset == 2'd3 |=> ptr == '0);

  p_side_rd_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en && offset != 2'd3 |=> rdata == 8'hFF);

  p_spare_wr_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en && offset == 2'd2 |=> $stable(ptr));

  p_lock_wr_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wr_en && offset == 2'd3 && !guarded && !oor);

  p_lock_rd_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en && offset == 2'd3 && guarded |=> rdata == 8'hFF);

  p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    lock_tgl |=> locks == ($past(locks) ^ (NUM_LOCKS'(1) << $past(lock_sel))));

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ptr == '0 && locks == '0 && rdata == 8'hFF);

  p_oor_rd_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en && offset == 2'd3 && oor |=> rdata == 8'hFF);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind nvp_port nvp_port_chk #(
  .MEM_BYTES(MEM_BYTES), .DW(DW), .NUM_LOCKS(NUM_LOCKS),
  .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .offset(offset),
  .wdata(wdata), .lock_tgl(lock_tgl), .lock_sel(lock_sel), .rdata(rdata),
  .ptr(ptr_q), .locks(lock_q), .mem_we(mem_we)
);

// File: tb/nvp_port_tb_top.sv
module nvp_port_tb_top;
  localparam int MEM = 2048;
  localparam int IW  = $clog2(MEM);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, lock_tgl = 1'b0;
  logic [1:0] offset = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       lock_sel = 1'b0;
  logic [7:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0]  mm [MEM];
  logic [15:0] mp = 16'h0;
  logic [1:0]  lk = 2'b00;

  always #10 clk = ~clk;

  nvp_port #(.MEM_BYTES(MEM)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .offset(offset),
    .wdata(wdata), .lock_tgl(lock_tgl), .lock_sel(lock_sel), .rdata(rdata)
  );

  function automatic bit usable(input logic [15:0] a);
    if (int'(a) >= MEM) return 0;
    if (lk[0] && a >= 16'h20 && a <= 16'h2F) return 0;
    if (lk[1] && a >= 16'h30 && a <= 16'h3F) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] o);
    if (o == 2'd3 && usable(mp)) return mm[mp[IW-1:0]];
    return 8'hFF;
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h (ptr=%h)", tag, got, exp, mp);
    end
  endtask

  task automatic wr(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; offset = o; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (o)
      2'd0: mp[7:0] = d;
      2'd1: mp[15:8] = d;
      2'd3: begin
        if (usable(mp)) mm[mp[IW-1:0]] = d;
        mp = 16'h0;
      end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] o, input string tag);
    logic [7:0] e;
    e = exp_read(o);
    @(negedge clk);
    rd_en = 1'b1; offset = o;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata, e, tag);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr(2'd0, a[7:0]);
    wr(2'd1, a[15:8]);
  endtask

  task automatic tgl(input logic s);
    @(negedge clk);
    lock_tgl = 1'b1; lock_sel = s;
    @(negedge clk);
    lock_tgl = 1'b0;
    lk[s] = ~lk[s];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected=<190000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata, 8'hFF, "R10 reset rdata");

    // fill every location with a known byte
    for (int a = 0; a < MEM; a++) begin
      set_ptr(16'(a));
      wr(2'd3, 8'(a * 7 + 3));
    end

    // R1 / R2: half-pointer loads
    set_ptr(16'h0123);
    wr(2'd0, 8'h45);
    rd(2'd3, "R1 low byte load");
    wr(2'd1, 8'h02);
    rd(2'd3, "R2 high byte load");

    // R3: store then pointer clears
    set_ptr(16'h0100);
    wr(2'd3, 8'hA5);
    rd(2'd3, "R3 pointer cleared");
    set_ptr(16'h0100);
    rd(2'd3, "R3 stored byte");
    check(mm[16'h100], 8'hA5, "R3 model");

    // R4 / R5
    set_ptr(16'h07FF);
    rd(2'd3, "R4 top location");
    rd(2'd0, "R5 offset 0");
    rd(2'd1, "R5 offset 1");
    rd(2'd2, "R5 offset 2");

    // R6: spare offset
    set_ptr(16'h0055);
    wr(2'd2, 8'h99);
    rd(2'd3, "R6 spare write");

    // R7 / R8 / R9: window locks and edges
    tgl(1'b0);
    set_ptr(16'h002F);
    wr(2'd3, 8'h11);
    set_ptr(16'h002F);
    rd(2'd3, "R8 locked read 0x2F");
    set_ptr(16'h0030);
    rd(2'd3, "R7 edge 0x30 open");
    set_ptr(16'h0020);
    rd(2'd3, "R8 locked read 0x20");
    tgl(1'b0);
    set_ptr(16'h002F);
    rd(2'd3, "R7 R9 store dropped, unlocked");
    tgl(1'b1);
    set_ptr(16'h003F);
    wr(2'd3, 8'h22);
    set_ptr(16'h003F);
    rd(2'd3, "R8 locked read 0x3F");
    set_ptr(16'h0040);
    rd(2'd3, "R7 edge 0x40 open");
    set_ptr(16'h001F);
    rd(2'd3, "R7 edge 0x1F open");
    set_ptr(16'h002A);
    rd(2'd3, "R9 other lock untouched");
    tgl(1'b1);
    set_ptr(16'h003F);
    rd(2'd3, "R7 R9 0x3F back");

    // R11: beyond the memory
    set_ptr(16'(MEM));
    wr(2'd3, 8'h77);
    set_ptr(16'(MEM));
    rd(2'd3, "R11 read past end");
    set_ptr(16'h0000);
    rd(2'd3, "R11 no alias write");
    set_ptr(16'hFFFF);
    rd(2'd3, "R11 read 0xFFFF");

    // R12: hold
    set_ptr(16'h0077);
    rd(2'd3, "R4 before hold");
    held = rdata;
    repeat (3) @(negedge clk);
    check(rdata, held, "R12 hold");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [7:0] b;
      k = $urandom_range(0, 9);
      b = 8'($urandom);
      case (k)
        0: wr(2'd0, ($urandom_range(0, 9) < 4) ? 8'($urandom_range(32, 63)) : b);
        1: wr(2'd1, ($urandom_range(0, 9) < 7) ? 8'($urandom_range(0, MEM / 256 - 1)) : b);
        2: wr(2'd3, b);
        3: wr(2'd2, b);
        4, 5, 6: rd(2'd3, "R4 random read");
        7: rd(2'($urandom_range(0, 2)), "R5 random side read");
        8: tgl(1'($urandom));
        default: begin
          set_ptr({8'($urandom_range(0, MEM / 256 - 1)), ($urandom_range(0, 1) == 1) ? 8'($urandom_range(32, 63)) : b});
          rd(2'd3, "R8 R11 random pointed read");
        end
      endcase
    end

    // R10: reset in mid-run
    if (lk[0] == 1'b0) tgl(1'b0);
    set_ptr(16'h0025);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mp = 16'h0; lk = 2'b00;
    check(rdata, 8'hFF, "R10 rdata after reset");
    rd(2'd3, "R10 pointer cleared");
    set_ptr(16'h0025);
    rd(2'd3, "R10 locks cleared");

    finish_run();
  end
endmodule